// File: doc/BRIEF.md
# Hardware Counting Semaphore

This block keeps one shared counting semaphore for a group of requesting agents. Each agent can ask to take a slot (acquire) or to give one back (release). The count of free slots can never fall below zero. When an acquire finds no free slot, the block does not refuse it. It records the agent as parked in a per-agent flag, and the agent waits for a later grant without sending the request again.

Only one operation changes the state in any clock cycle, so each acquire or release is indivisible with respect to every other agent. When several agents request in the same cycle, a fixed-priority arbiter picks one of them. The others see no acknowledge and keep their request asserted. A release that finds parked agents does not raise the count. It passes its slot straight to one parked agent, chosen round-robin starting after the agent woken last, so no other agent can take that slot in between. The reset count sets how many agents can hold the semaphore at the same time.

Top module: `csem_top`

## Requirements
- R1: After reset the count equals INIT_CNT, no agent is parked, and ack, grant and rel_err are all low.
- R2: An acquire served while the count is above zero pulses that agent's ack and grant one cycle later, and the count drops by one.
- R3: An acquire served while the count is zero pulses ack but not grant, sets that agent's waiting bit, and leaves the count at zero.
- R4: A release served with no agent parked and the count below MAX_CNT pulses ack, and the count rises by one.
- R5: A release served while agents are parked leaves the count unchanged. Exactly one parked agent gets a grant pulse, and its waiting bit clears in the same cycle.
- R6: The agent woken by a release is the first parked agent found when searching upward with wrap-around, starting just after the agent woken last. Before any wake-up, the search starts at agent 0.
- R7: When several eligible agents request in one cycle, only the lowest-numbered one is served and acknowledged, and at most one operation completes per cycle.
- R8: A release served with no agent parked and the count equal to MAX_CNT pulses ack and rel_err, and leaves the count unchanged.
- R9: An agent that asserts acquire and release in the same cycle is served as a release.
- R10: Requests from an agent whose waiting bit is set are ignored: that agent gets no ack, and the count and waiting bits do not change.
- R11: The count never exceeds MAX_CNT, and an agent is parked only while the count is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| acq_req | input | N_AGENTS | Per-agent acquire request, held until acknowledged |
| rel_req | input | N_AGENTS | Per-agent release request, held until acknowledged |
| ack | output | N_AGENTS | One-hot pulse: this agent's request was served |
| grant | output | N_AGENTS | One-hot pulse: this agent now holds a slot |
| waiting | output | N_AGENTS | Per-agent parked flag |
| count | output | CNT_W | Current number of free slots |
| rel_err | output | 1 | Pulse: release at full count with nobody parked |

## Verification
The bench sweeps all 256 combinations of the four acquire masks and four release masks, one after another, starting from states the sweep itself produces. In that run, same-cycle conflicts separate fixed priority from other orders, and the requests of parked agents show whether they are filtered out. Directed sequences then drain the count to zero and park several agents. Releases follow, and the order in which parked agents are woken separates round-robin from lowest-first selection. Releases at full count check the error pulse, and an agent that asserts both requests at once shows which request wins.

// File: rtl/csem_pkg.sv
package csem_pkg;
   typedef enum logic [1:0] {
      OP_NONE = 2'd0,
      OP_ACQ  = 2'd1,
      OP_REL  = 2'd2
   } sem_op_e;
endpackage

// File: rtl/csem_arb.sv
module csem_arb #(
   parameter int N         = 4,
   parameter bit LOW_FIRST = 1'b1,
   localparam int IW       = $clog2(N)
) (
   input  logic [N-1:0]  req,
   output logic [N-1:0]  win_oh,
   output logic [IW-1:0] win_idx,
   output logic          win_vld
);
   generate
      if (LOW_FIRST) begin : g_low
         always_comb begin
            win_oh  = '0;
            win_idx = '0;
            for (int i = N - 1; i >= 0; i--) begin
               if (req[i]) begin
                  win_oh  = '0;
                  win_oh[i] = 1'b1;
                  win_idx = IW'(i);
               end
            end
         end
      end else begin : g_high
         always_comb begin
            win_oh  = '0;
            win_idx = '0;
            for (int i = 0; i < N; i++) begin
               if (req[i]) begin
                  win_oh  = '0;
                  win_oh[i] = 1'b1;
                  win_idx = IW'(i);
               end
            end
         end
      end
   endgenerate

   assign win_vld = |req;

   always_comb begin
      assert_arb_onehot_R7: assert ($onehot0(win_oh));
   end
endmodule

// File: rtl/csem_rr_pick.sv
module csem_rr_pick #(
   parameter int N   = 4,
   localparam int IW = $clog2(N)
) (
   input  logic [N-1:0]  cand,
   input  logic [IW-1:0] last,
   output logic [N-1:0]  pick_oh,
   output logic [IW-1:0] pick_idx,
   output logic          found
);
   always_comb begin
      pick_oh  = '0;
      pick_idx = '0;
      found    = 1'b0;
      for (int off = 1; off <= N; off++) begin
         int idx;
         idx = (int'(last) + off) % N;
         if (!found && cand[idx]) begin
            found        = 1'b1;
            pick_oh[idx] = 1'b1;
            pick_idx     = IW'(idx);
         end
      end
   end

   always_comb begin
      assert_pick_valid_R6: assert (!found || ((pick_oh & cand) != '0));
   end
endmodule

// File: rtl/csem_top.sv
module csem_top #(
   parameter int N_AGENTS  = 4,
   parameter int CNT_W     = 3,
   parameter int MAX_CNT   = 2,
   parameter int INIT_CNT  = 2,
   parameter bit LOW_FIRST = 1'b1,
   localparam int IW       = $clog2(N_AGENTS)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [N_AGENTS-1:0] acq_req,
   input  logic [N_AGENTS-1:0] rel_req,
   output logic [N_AGENTS-1:0] ack,
   output logic [N_AGENTS-1:0] grant,
   output logic [N_AGENTS-1:0] waiting,
   output logic [CNT_W-1:0]    count,
   output logic                rel_err
);
   import csem_pkg::*;

   localparam logic [CNT_W-1:0] CMAX  = CNT_W'(MAX_CNT);
   localparam logic [CNT_W-1:0] CINIT = CNT_W'(INIT_CNT);
   localparam logic [IW-1:0]    LAST0 = IW'(N_AGENTS - 1);

   generate
      if (N_AGENTS < 2) begin : g_chk_agents
         $error("csem_top: N_AGENTS must be at least 2");
      end
      if (MAX_CNT >= (1 << CNT_W) || MAX_CNT < 1) begin : g_chk_max
         $error("csem_top: MAX_CNT does not fit CNT_W");
      end
      if (INIT_CNT > MAX_CNT || INIT_CNT < 0) begin : g_chk_init
         $error("csem_top: INIT_CNT outside 0..MAX_CNT");
      end
   endgenerate

   logic [N_AGENTS-1:0] wait_q, wait_d, ack_q, ack_d, grant_q, grant_d;
   logic [CNT_W-1:0]    cnt_q, cnt_d;
   logic [IW-1:0]       last_q, last_d;
   logic                err_q, err_d;

   logic [N_AGENTS-1:0] elig, win_oh, pick_oh;
   logic [IW-1:0]       win_idx, pick_idx;
   logic                win_vld, found;
   sem_op_e             op;

   assign elig = (acq_req | rel_req) & ~wait_q;

   csem_arb #(.N(N_AGENTS), .LOW_FIRST(LOW_FIRST)) u_arb (
      .req     (elig),
      .win_oh  (win_oh),
      .win_idx (win_idx),
      .win_vld (win_vld)
   );

   csem_rr_pick #(.N(N_AGENTS)) u_pick (
      .cand     (wait_q),
      .last     (last_q),
      .pick_oh  (pick_oh),
      .pick_idx (pick_idx),
      .found    (found)
   );

   always_comb begin
      if (!win_vld)              op = OP_NONE;
      else if (rel_req[win_idx]) op = OP_REL;
      else                       op = OP_ACQ;
   end

   always_comb begin
      cnt_d   = cnt_q;
      wait_d  = wait_q;
      last_d  = last_q;
      ack_d   = win_oh;
      grant_d = '0;
      err_d   = 1'b0;
      case (op)
         OP_ACQ: begin
            if (cnt_q != '0) begin
               cnt_d   = cnt_q - CNT_W'(1);
               grant_d = win_oh;
            end else begin
               wait_d = wait_q | win_oh;
            end
         end
         OP_REL: begin
            if (found) begin
               wait_d  = wait_q & ~pick_oh;
               grant_d = pick_oh;
               last_d  = pick_idx;
            end else if (cnt_q == CMAX) begin
               err_d = 1'b1;
            end else begin
               cnt_d = cnt_q + CNT_W'(1);
            end
         end
         default: ;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q   <= CINIT;
         wait_q  <= '0;
         last_q  <= LAST0;
         ack_q   <= '0;
         grant_q <= '0;
         err_q   <= 1'b0;
      end else begin
         cnt_q   <= cnt_d;
         wait_q  <= wait_d;
         last_q  <= last_d;
         ack_q   <= ack_d;
         grant_q <= grant_d;
         err_q   <= err_d;
      end
   end

   assign ack     = ack_q;
   assign grant   = grant_q;
   assign waiting = wait_q;
   assign count   = cnt_q;
   assign rel_err = err_q;

   assert_cnt_bound_R11: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= CMAX);
   assert_park_at_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (wait_q != '0) |-> (cnt_q == '0));
   assert_one_op_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(ack_q) && $onehot0(grant_q));
   assert_handoff_keeps_cnt_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (op == OP_REL && wait_q != '0) |=> ($stable(cnt_q) && $countones(grant_q) == 1));
   assert_err_keeps_cnt_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (op == OP_REL && wait_q == '0 && cnt_q == CMAX) |=> (err_q && $stable(cnt_q)));
   assert_no_neg_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (op == OP_ACQ && cnt_q == '0) |=> (cnt_q == '0 && grant_q == '0));
endmodule

// File: tb/sim_csem_top.sv
module sim_csem_top;
   localparam int N = 4;
   localparam int W = 3;
   localparam int MAXC = 2;
   localparam int INITC = 2;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic [N-1:0] acq_req = '0, rel_req = '0;
   logic [N-1:0] ack, grant, waiting;
   logic [W-1:0] count;
   logic         rel_err;

   int checks = 0;
   int fails  = 0;

   int           m_cnt;
   logic [N-1:0] m_wait;
   int           m_last;

   always #5 clk = ~clk;

   csem_top #(.N_AGENTS(N), .CNT_W(W), .MAX_CNT(MAXC), .INIT_CNT(INITC), .LOW_FIRST(1'b1)) u0 (
      .clk(clk), .rst_n(rst_n), .acq_req(acq_req), .rel_req(rel_req),
      .ack(ack), .grant(grant), .waiting(waiting), .count(count), .rel_err(rel_err)
   );

   task automatic chk(input string tag, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
      end
   endtask

   // One request cycle: model computes the expectation from the requirements.
   task automatic op(input string tag, input logic [N-1:0] a, input logic [N-1:0] r);
      logic [N-1:0] elig, e_ack, e_grant;
      logic         e_err;
      int           w;
      w = -1; e_ack = '0; e_grant = '0; e_err = 1'b0;
      elig = (a | r) & ~m_wait;                     // R10: parked agents filtered
      for (int i = N - 1; i >= 0; i--) if (elig[i]) w = i;   // R7: lowest wins
      if (w >= 0) begin
         e_ack[w] = 1'b1;
         if (r[w]) begin                             // R9: release wins
            int pk;
            pk = -1;
            for (int off = 1; off <= N; off++)
               if (pk < 0 && m_wait[(m_last + off) % N]) pk = (m_last + off) % N;
            if (pk >= 0) begin                       // R5, R6
               m_wait[pk] = 1'b0; e_grant[pk] = 1'b1; m_last = pk;
            end else if (m_cnt == MAXC) e_err = 1'b1; // R8
            else m_cnt++;                            // R4
         end else begin
            if (m_cnt > 0) begin m_cnt--; e_grant[w] = 1'b1; end  // R2
            else m_wait[w] = 1'b1;                   // R3
         end
      end
      @(negedge clk);
      acq_req = a; rel_req = r;
      @(posedge clk);
      #1;
      acq_req = '0; rel_req = '0;
      chk(tag, "ack", int'(ack), int'(e_ack));
      chk(tag, "grant", int'(grant), int'(e_grant));
      chk(tag, "rel_err", int'(rel_err), int'(e_err));
      chk(tag, "count", int'(count), m_cnt);
      chk(tag, "waiting", int'(waiting), int'(m_wait));
      chk("R11", "count<=max", int'(count <= MAXC), 1);
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      fails++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      m_cnt = INITC; m_wait = '0; m_last = N - 1;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      #1;
      chk("R1", "count", int'(count), INITC);
      chk("R1", "waiting", int'(waiting), 0);
      chk("R1", "ack", int'(ack), 0);
      chk("R1", "grant", int'(grant), 0);
      chk("R1", "rel_err", int'(rel_err), 0);

      op("R8", 4'b0000, 4'b0001);   // release at full count
      op("R2", 4'b0001, 4'b0000);
      op("R2", 4'b0010, 4'b0000);
      op("R3", 4'b0100, 4'b0000);   // park agent 2
      op("R3", 4'b1000, 4'b0000);   // park agent 3
      op("R10", 4'b0100, 4'b0100);  // parked agent ignored
      op("R10", 4'b0000, 4'b1000);
      op("R6", 4'b0000, 4'b0001);   // wakes agent 2
      op("R5", 4'b0000, 4'b0010);   // wakes agent 3
      op("R4", 4'b0000, 4'b0100);
      op("R4", 4'b0000, 4'b1000);
      op("R7", 4'b1010, 4'b0000);   // agent 1 only
      op("R7", 4'b1000, 4'b0000);
      op("R3", 4'b0001, 4'b0000);   // park 0
      op("R3", 4'b0100, 4'b0000);   // park 2
      op("R3", 4'b0010, 4'b0000);   // park 1
      op("R6", 4'b0000, 4'b1000);   // last=3 -> agent 0
      op("R6", 4'b0000, 4'b0001);   // after 0 -> agent 1
      op("R6", 4'b0000, 4'b0010);   // after 1 -> agent 2
      op("R9", 4'b0100, 4'b0100);   // both -> release
      op("R9", 4'b0001, 4'b0001);
      op("R8", 4'b0000, 4'b0010);

      for (int v = 0; v < 256; v++)
         op("R7", 4'(v), 4'(v >> 4));

      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule